// File: doc/BRIEF.md
# Operate Instruction Execute Unit

This unit carries out the three arithmetic and logic operations of a 16-bit load/store processor: addition, bitwise AND and bitwise inversion. Each cycle it may receive one instruction word, marked by a valid strobe. From the word it derives the two register-file read indices. It takes the two values the register file returns and produces the result, the destination index and a write enable, all in the same cycle.

The unit also owns the three-flag condition-code register (negative, zero, positive). Every register write that the unit performs reloads this register from the result, and the new value is visible after the next rising clock edge. Any other opcode passes through without writing and without touching the flags. The register storage itself sits outside the unit, as do memory access and fetch.

Top module: `operate_exec_unit`

## Requirements
- R1: With `issue_vld` high, opcode bits [15:12] of 4'b0001 (add), 4'b0101 (and) and 4'b1001 (invert) raise `wr_en` in the same cycle; `wr_en` is never high while `issue_vld` is low.
- R2: Any other opcode, or `issue_vld` low, keeps `wr_en` low and leaves the three flags unchanged.
- R3: `dest_idx` equals instruction bits [11:9], `sel_a` equals bits [8:6] and `sel_b` equals bits [2:0].
- R4: Add with bit 5 = 0 returns `opnd_a + opnd_b` modulo 2^16 (for example 0xFFF6 + 0x0008 = 0xFFFE, 0x7FFF + 1 = 0x8000).
- R5: Add and AND with bit 5 = 1 use bits [4:0] sign-extended to 16 bits as the second operand, and `opnd_b` has no effect on the result.
- R6: AND with bit 5 = 0 returns the bitwise AND of `opnd_a` and `opnd_b`.
- R7: Invert returns the bitwise complement of `opnd_a`; bits [5:0] of the word have no effect.
- R8: After a cycle with `wr_en` high, the next clock edge sets the flags from the result: N when bit 15 is 1, Z when the result is zero, P otherwise.
- R9: A synchronous active-low reset sets the flags to Z only.
- R10: Out of reset, exactly one of the three flags is set at every clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_vld | input | 1 | Marks a valid instruction this cycle |
| instr | input | 16 | Instruction word |
| opnd_a | input | 16 | Register value read at `sel_a` |
| opnd_b | input | 16 | Register value read at `sel_b` |
| sel_a | output | 3 | First source register index |
| sel_b | output | 3 | Second source register index |
| res_data | output | 16 | Result to write back |
| dest_idx | output | 3 | Destination register index |
| wr_en | output | 1 | Register write enable |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_p | output | 1 | Positive flag |

## Verification
The hardest condition to show from the ports is that flags survive a cycle without a write. A flag register that reloads on every strobe, or from any opcode, looks correct whenever writes follow one another. The stimulus therefore first sets a flag value that differs from what a stray result would give. It then issues foreign opcodes and idle valid-low words whose operands would classify differently, and checks after each one that the old flag still holds. The immediate path is tested the same way: `opnd_b` carries a value that would change the answer if it leaked through, and the immediate sits at the −16 and +15 extremes.

// File: rtl/opx_pkg.sv
// Shared types and constants for the operate execute unit.
// Assumes the 16-bit instruction layout with a 4-bit opcode on top.
package opx_pkg;

    localparam int INSTR_W   = 16;
    localparam int REG_IDX_W = 3;
    localparam int IMM_W     = 5;

    localparam logic [3:0] OPC_SUM  = 4'b0001;
    localparam logic [3:0] OPC_MASK = 4'b0101;
    localparam logic [3:0] OPC_INV  = 4'b1001;

    typedef enum logic [1:0] {
        OPK_NONE,
        OPK_SUM,
        OPK_MASK,
        OPK_INV
    } opk_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic pos;
    } cc_t;

    localparam cc_t CC_RESET = '{neg: 1'b0, zero: 1'b1, pos: 1'b0};

endpackage

// File: rtl/opx_decode.sv
// Instruction field decoder. Splits the word into operation kind,
// register indices and the sign-extended immediate operand.
// Assumes DATA_W >= IMM_W; purely combinational.
module opx_decode
    import opx_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [INSTR_W-1:0]   instr,
    output opk_e                 kind,
    output logic                 imm_mode,
    output logic [REG_IDX_W-1:0] dst,
    output logic [REG_IDX_W-1:0] src1,
    output logic [REG_IDX_W-1:0] src2,
    output logic [DATA_W-1:0]    imm_ext
);

    localparam int EXT_W = DATA_W - IMM_W;

    // Classify the opcode field.
    always_comb begin
        unique case (instr[15:12])
            OPC_SUM:  kind = OPK_SUM;
            OPC_MASK: kind = OPK_MASK;
            OPC_INV:  kind = OPK_INV;
            default:  kind = OPK_NONE;
        endcase
    end

    // Extract register fields and the mode bit.
    always_comb begin
        dst      = instr[11:9];
        src1     = instr[8:6];
        src2     = instr[2:0];
        imm_mode = instr[5];
    end

    // Sign-extend the immediate field to the data width.
    always_comb begin
        imm_ext = {{EXT_W{instr[IMM_W-1]}}, instr[IMM_W-1:0]};
    end

endmodule

// File: rtl/opx_alu.sv
// Operate datapath: selects the second operand and computes the add,
// AND or invert result. Assumes kind comes from opx_decode.
module opx_alu
    import opx_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  opk_e              kind,
    input  logic              imm_mode,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [DATA_W-1:0] imm_ext,
    output logic [DATA_W-1:0] result
);

    logic [DATA_W-1:0] b_eff;

    // Pick the register or immediate second operand.
    always_comb begin
        b_eff = imm_mode ? imm_ext : b;
    end

    // Compute the result for the decoded operation.
    always_comb begin
        unique case (kind)
            OPK_SUM:  result = a + b_eff;
            OPK_MASK: result = a & b_eff;
            OPK_INV:  result = ~a;
            default:  result = '0;
        endcase
    end

endmodule

// File: rtl/opx_ccreg.sv
// Condition-code register. Classifies a written value as negative,
// zero or positive and loads it on the next edge when load is high.
// Assumes a synchronous active-low reset.
module opx_ccreg
    import opx_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] value,
    output cc_t               cc
);

    cc_t cc_next;

    // Classify the incoming value into one flag.
    always_comb begin
        cc_next.neg  = value[DATA_W-1];
        cc_next.zero = (value == '0);
        cc_next.pos  = !value[DATA_W-1] && (value != '0);
    end

    // Hold the flags; reload on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cc <= CC_RESET;
        else if (load)
            cc <= cc_next;
    end

    // R10
    cc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(cc));

    // R2
    cc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cc));

    // R8
    cc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && value == '0) |=> cc.zero);

    // R8
    cc_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && value[DATA_W-1]) |=> cc.neg);

endmodule

// File: rtl/operate_exec_unit.sv
// Top of the operate execute unit. Decodes one instruction per valid
// cycle, returns result, destination and write enable in that cycle,
// and updates the condition flags on the following edge.
// Assumes the register file reads sel_a/sel_b combinationally.
module operate_exec_unit
    import opx_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 issue_vld,
    input  logic [INSTR_W-1:0]   instr,
    input  logic [DATA_W-1:0]    opnd_a,
    input  logic [DATA_W-1:0]    opnd_b,
    output logic [REG_IDX_W-1:0] sel_a,
    output logic [REG_IDX_W-1:0] sel_b,
    output logic [DATA_W-1:0]    res_data,
    output logic [REG_IDX_W-1:0] dest_idx,
    output logic                 wr_en,
    output logic                 flag_n,
    output logic                 flag_z,
    output logic                 flag_p
);

    opk_e              kind;
    logic              imm_mode;
    logic [DATA_W-1:0] imm_ext;
    cc_t               cc;

    opx_decode #(.DATA_W(DATA_W)) u_decode (
        .instr    (instr),
        .kind     (kind),
        .imm_mode (imm_mode),
        .dst      (dest_idx),
        .src1     (sel_a),
        .src2     (sel_b),
        .imm_ext  (imm_ext)
    );

    opx_alu #(.DATA_W(DATA_W)) u_alu (
        .kind     (kind),
        .imm_mode (imm_mode),
        .a        (opnd_a),
        .b        (opnd_b),
        .imm_ext  (imm_ext),
        .result   (res_data)
    );

    // Write only for a valid, recognised operation.
    always_comb begin
        wr_en = issue_vld && (kind != OPK_NONE);
    end

    opx_ccreg #(.DATA_W(DATA_W)) u_ccreg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (wr_en),
        .value (res_data),
        .cc    (cc)
    );

    // Drive the flag pins from the register.
    always_comb begin
        flag_n = cc.neg;
        flag_z = cc.zero;
        flag_p = cc.pos;
    end

    // R1
    we_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> issue_vld);

    // R2
    foreign_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[15:12] != OPC_SUM && instr[15:12] != OPC_MASK &&
         instr[15:12] != OPC_INV) |-> !wr_en);

    // R7
    inv_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && instr[15:12] == OPC_INV) |-> ((res_data ^ opnd_a) == '1));

endmodule

// File: tb/test_operate_exec_unit.sv
module test_operate_exec_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_vld = 1'b0;
    logic [15:0] instr = '0;
    logic [15:0] opnd_a = '0;
    logic [15:0] opnd_b = '0;
    logic [2:0]  sel_a, sel_b, dest_idx;
    logic [15:0] res_data;
    logic        wr_en, flag_n, flag_z, flag_p;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        string       tag;
        logic [15:0] ins;
        logic        we;
        logic [15:0] res;
        logic [2:0]  cc;
    } item_t;

    item_t q[$];
    logic [2:0] model_cc = 3'b010;

    always #(CLK_PERIOD/2) clk = ~clk;

    operate_exec_unit i_operate_exec_unit (
        .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .instr(instr),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .sel_a(sel_a), .sel_b(sel_b),
        .res_data(res_data), .dest_idx(dest_idx), .wr_en(wr_en),
        .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] w_reg(logic [3:0] op, logic [2:0] d, logic [2:0] s1, logic [2:0] s2);
        return {op, d, s1, 3'b000, s2};
    endfunction

    function automatic logic [15:0] w_imm(logic [3:0] op, logic [2:0] d, logic [2:0] s1, logic [4:0] im);
        return {op, d, s1, 1'b1, im};
    endfunction

    function automatic logic [2:0] classify(logic [15:0] v);
        if (v[15]) return 3'b100;
        if (v == 16'h0) return 3'b010;
        return 3'b001;
    endfunction

    // Driver: apply one word and push the expected outcome.
    task automatic send(string tag, logic vld, logic [15:0] w, logic [15:0] a, logic [15:0] b);
        item_t it;
        logic [15:0] bm;
        @(negedge clk);
        issue_vld = vld; instr = w; opnd_a = a; opnd_b = b;
        bm = w[5] ? {{11{w[4]}}, w[4:0]} : b;
        it.tag = tag; it.ins = w; it.we = 1'b0; it.res = '0;
        case (w[15:12])
            4'b0001: begin it.we = vld; it.res = a + bm; end
            4'b0101: begin it.we = vld; it.res = a & bm; end
            4'b1001: begin it.we = vld; it.res = ~a; end
            default: it.we = 1'b0;
        endcase
        if (it.we) model_cc = classify(it.res);
        it.cc = model_cc;
        q.push_back(it);
    endtask

    // Monitor: compare same-cycle outputs, then flags after the edge.
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                it = q.pop_front();
                check({it.tag, " R1/R2 wr_en"}, 32'(wr_en), 32'(it.we));
                check({it.tag, " R3 dest"}, 32'(dest_idx), 32'(it.ins[11:9]));
                check({it.tag, " R3 sel_a"}, 32'(sel_a), 32'(it.ins[8:6]));
                check({it.tag, " R3 sel_b"}, 32'(sel_b), 32'(it.ins[2:0]));
                if (it.we) check({it.tag, " result"}, 32'(res_data), 32'(it.res));
                @(posedge clk);
                #1;
                check({it.tag, " R8 flags"}, 32'({flag_n, flag_z, flag_p}), 32'(it.cc));
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R9 reset flags", 32'({flag_n, flag_z, flag_p}), 32'(3'b010));
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R9 flags after release", 32'({flag_n, flag_z, flag_p}), 32'(3'b010));
        check("R1 idle wr_en", 32'(wr_en), 32'(0));

        send("R4 add wrap neg", 1, w_reg(4'b0001, 3'd6, 3'd3, 3'd2), 16'hFFF6, 16'h0008);
        send("R4 add to zero", 1, w_reg(4'b0001, 3'd1, 3'd7, 3'd5), 16'hFFFF, 16'h0001);
        send("R4 add overflow", 1, w_reg(4'b0001, 3'd0, 3'd0, 3'd0), 16'h7FFF, 16'h0001);
        send("R5 add imm -1", 1, w_imm(4'b0001, 3'd2, 3'd4, 5'h1F), 16'h0010, 16'hAAAA);
        send("R5 add imm +15", 1, w_imm(4'b0001, 3'd3, 3'd3, 5'h0F), 16'h7FF0, 16'h8000);
        send("R5 add imm -16", 1, w_imm(4'b0001, 3'd5, 3'd1, 5'h10), 16'h0010, 16'h1234);
        send("R6 and reg", 1, w_reg(4'b0101, 3'd4, 3'd2, 3'd6), 16'hFFF6, 16'h0F0F);
        send("R6 and reg neg", 1, w_reg(4'b0101, 3'd7, 3'd1, 3'd2), 16'hF0F0, 16'h8F00);
        send("R5 and imm", 1, w_imm(4'b0101, 3'd1, 3'd3, 5'h15), 16'hFFF6, 16'h0000);
        send("R5 and imm zero", 1, w_imm(4'b0101, 3'd2, 3'd2, 5'h00), 16'hBEEF, 16'hFFFF);
        send("R7 invert", 1, {4'b1001, 3'd5, 3'd3, 6'b111111}, 16'hFFF6, 16'h0000);
        send("R7 invert low bits", 1, {4'b1001, 3'd5, 3'd3, 6'b010101}, 16'h00FF, 16'hFFFF);
        send("R7 invert to zero", 1, {4'b1001, 3'd0, 3'd6, 6'b000000}, 16'hFFFF, 16'h1234);
        // zero flag now set; foreign opcodes would classify as N or P
        send("R2 opcode 0000", 1, 16'h0E3F, 16'h8000, 16'h8000);
        send("R2 opcode 0010", 1, 16'h2FFF, 16'h0001, 16'h0001);
        send("R2 opcode 1101", 1, 16'hD020, 16'h8000, 16'h0000);
        send("R2 opcode 0100", 1, 16'h4000, 16'h1234, 16'h0001);
        send("R2 add without valid", 0, w_reg(4'b0001, 3'd1, 3'd2, 3'd3), 16'h8000, 16'h0001);
        send("R2 inv without valid", 0, {4'b1001, 3'd1, 3'd2, 6'h3F}, 16'h0000, 16'h0000);
        send("R8 add positive", 1, w_reg(4'b0001, 3'd1, 3'd2, 3'd3), 16'h0001, 16'h0002);
        send("R2 opcode 1111", 1, 16'hF025, 16'h0000, 16'h0000);
        send("R4 add neg plus neg", 1, w_reg(4'b0001, 3'd3, 3'd4, 3'd5), 16'h8000, 16'hFFFF);

        @(negedge clk);
        issue_vld = 1'b0;
        while (q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule